// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

This block collects a small, parameterised set of maskable interrupt sources for a simple 8-bit processor and turns them into a single vectored request. Every source owns a pending flag and a mask bit. A hardware pulse sets the pending flag. Software can also overwrite the whole pending vector or the whole mask vector in one write. A source competes for service only while its pending flag is 1 and its mask bit is 0. The global enable bit of the processor status byte must also be 1 before the block raises its request. Among competing sources, the lowest-numbered one wins, and its number is presented as the vector index.

The processor status byte lives inside the block. The processor reads it, writes it as a whole byte, changes a single bit of it, or sets or clears the global enable with dedicated strobes. When the processor accepts the request at an instruction boundary, it raises acknowledge. In that same cycle the block emits a push strobe carrying the current status byte for the stack. On the following edge the block clears the global enable and the winner's pending flag. Four positions of the status byte are fixed and cannot be changed: bit 1 is always 1, and bits 2, 3 and 5 are always 0. After reset the status byte is 02H.

Top module: `mvic_top`

## Requirements
- R1: A source is eligible when its pending flag is 1 and its mask bit is 0. While the request is raised, `irq_vec` names an eligible source, and masking every eligible source drops the request.
- R2: `irq_out` is 1 exactly when at least one source is eligible and the global enable (status bit 7) is 1.
- R3: When `ack_in` is 1 while `irq_out` is 1, `stk_push` is 1 in that same cycle and `stk_data` carries the status byte from before the acknowledge. From the next edge onward, status bit 7 reads 0.
- R4: After reset, the status byte reads 02H, all pending flags read 0, all mask bits read 1, and `irq_out` is 0.
- R5: Status bit 1 always reads 1 and bits 5, 3 and 2 always read 0, whatever is written. Bit 7 holds the global enable, bit 6 the zero flag, bit 4 the auxiliary carry and bit 0 the carry. Writing FFH reads back D3H.
- R6: When several sources are eligible, `irq_vec` gives the lowest index among them.
- R7: On an accepted acknowledge, the winning source's pending flag is cleared at the next edge. A request pulse on that same source in that same cycle leaves the flag at 1.
- R8: A request pulse sets its pending flag at the next edge. A pending-vector write replaces all flags with `flag_wr_data`, and a same-cycle pulse still sets its bit over the written value.
- R9: An `ack_in` while `irq_out` is 0 is ignored: no push, and the status byte and pending flags keep their values.
- R10: Status updates in one cycle apply in this order, each later step overriding the earlier ones: byte write, then single-bit write (`psw_bit_sel` selects the bit), then enable set, then enable clear, then clearing by an accepted acknowledge.
- R11: A mask write replaces all mask bits with `mask_wr_data` at the next edge.
- R12: With the global enable at 1 and the source unmasked, `irq_out` rises on the first edge after the request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | N_SRC | One-cycle request pulses, one per source |
| flag_wr_en | input | 1 | Replace the pending-flag vector |
| flag_wr_data | input | N_SRC | New pending-flag vector |
| mask_wr_en | input | 1 | Replace the mask vector |
| mask_wr_data | input | N_SRC | New mask vector (1 = masked) |
| psw_wr_en | input | 1 | Write the whole status byte |
| psw_wr_data | input | 8 | New status byte |
| psw_bit_we | input | 1 | Write one status bit |
| psw_bit_sel | input | 3 | Index of the status bit to write |
| psw_bit_val | input | 1 | Value for the selected bit |
| ie_set | input | 1 | Set the global enable |
| ie_clr | input | 1 | Clear the global enable |
| ack_in | input | 1 | Processor accepts the interrupt at an instruction boundary |
| irq_out | output | 1 | Vectored interrupt request to the processor |
| irq_vec | output | VEC_W | Index of the winning source |
| stk_push | output | 1 | Push strobe toward the stack |
| stk_data | output | 8 | Status byte to push |
| psw_rd | output | 8 | Current status byte |
| flag_rd | output | N_SRC | Current pending flags |
| mask_rd | output | N_SRC | Current mask bits |

## Verification
Directed patterns come first. The first places two pulses in one cycle on sources 0 and 5, while source 2 is already pending, which separates lowest-index arbitration from arrival order. The second acknowledges while a new pulse hits the winner, which tells a lost request from a preserved one. The third acknowledges with the request low, which shows whether a stray acknowledge is really ignored. The fourth sends conflicting status strokes in one cycle, which exposes the precedence order and the fixed bits. A seeded random phase then mixes sparse pulses, mask and flag rewrites, enable toggles and stray acknowledges with a processor model that acknowledges 9 to 19 cycles after seeing the request, and every cycle is compared against a bench model built from the requirements.

// File: rtl/mvic_pkg.sv
`timescale 1ns/1ps
package mvic_pkg;
   localparam int PSW_W      = 8;
   localparam int IE_POS     = 7;
   localparam int ZF_POS     = 6;
   localparam int AC_POS     = 4;
   localparam int CY_POS     = 0;
   localparam logic [PSW_W-1:0] PSW_RST     = 8'h02;
   localparam logic [PSW_W-1:0] PSW_FORCE1  = 8'h02;
   localparam logic [PSW_W-1:0] PSW_FORCE0  = 8'h2C;

   // Command bundle steering the status register for one cycle.
   typedef struct packed {
      logic             byte_we;
      logic [PSW_W-1:0] byte_d;
      logic             bit_we;
      logic [2:0]       bit_sel;
      logic             bit_d;
      logic             en_set;
      logic             en_clr;
      logic             take;
   } psw_cmd_t;

   function automatic logic [PSW_W-1:0] psw_legal(input logic [PSW_W-1:0] v);
      return (v & ~PSW_FORCE0) | PSW_FORCE1;
   endfunction
endpackage

// File: rtl/mvic_flags.sv
`timescale 1ns/1ps
module mvic_flags #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_pulse,
   input  logic             flag_we,
   input  logic [N_SRC-1:0] flag_d,
   input  logic             mask_we,
   input  logic [N_SRC-1:0] mask_d,
   input  logic [N_SRC-1:0] clr_onehot,
   output logic [N_SRC-1:0] flag_q,
   output logic [N_SRC-1:0] mask_q,
   output logic [N_SRC-1:0] elig
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic base;
      assign base = flag_we ? flag_d[i] : flag_q[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
            mask_q[i] <= 1'b1;
         end else begin
            flag_q[i] <= (base & ~clr_onehot[i]) | req_pulse[i];
            if (mask_we) mask_q[i] <= mask_d[i];
         end
      end

      assign elig[i] = flag_q[i] & ~mask_q[i];
   end
endmodule

// File: rtl/mvic_prio.sv
`timescale 1ns/1ps
module mvic_prio #(
   parameter int N_SRC = 8,
   parameter int VEC_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] elig,
   output logic             any,
   output logic [N_SRC-1:0] grant,
   output logic [VEC_W-1:0] vec
);
   logic [N_SRC-1:0] above;

   assign above[0] = 1'b0;
   for (genvar i = 1; i < N_SRC; i++) begin : g_chain
      assign above[i] = above[i-1] | elig[i-1];
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_grant
      assign grant[i] = elig[i] & ~above[i];
   end

   assign any = |elig;

   always_comb begin
      vec = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (grant[i]) vec = vec | VEC_W'(i);
      end
   end
endmodule

// File: rtl/mvic_psw.sv
`timescale 1ns/1ps
module mvic_psw
   import mvic_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  psw_cmd_t         cmd,
   output logic [PSW_W-1:0] psw_q
);
   logic [PSW_W-1:0] nxt;

   always_comb begin
      nxt = psw_q;
      if (cmd.byte_we) nxt = cmd.byte_d;
      if (cmd.bit_we)  nxt[cmd.bit_sel] = cmd.bit_d;
      if (cmd.en_set)  nxt[IE_POS] = 1'b1;
      if (cmd.en_clr)  nxt[IE_POS] = 1'b0;
      if (cmd.take)    nxt[IE_POS] = 1'b0;
      nxt = psw_legal(nxt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) psw_q <= PSW_RST;
      else        psw_q <= nxt;
   end
endmodule

// File: rtl/mvic_top.sv
`timescale 1ns/1ps
module mvic_top
   import mvic_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int VEC_W = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_pulse,
   input  logic             flag_wr_en,
   input  logic [N_SRC-1:0] flag_wr_data,
   input  logic             mask_wr_en,
   input  logic [N_SRC-1:0] mask_wr_data,
   input  logic             psw_wr_en,
   input  logic [7:0]       psw_wr_data,
   input  logic             psw_bit_we,
   input  logic [2:0]       psw_bit_sel,
   input  logic             psw_bit_val,
   input  logic             ie_set,
   input  logic             ie_clr,
   input  logic             ack_in,
   output logic             irq_out,
   output logic [VEC_W-1:0] irq_vec,
   output logic             stk_push,
   output logic [7:0]       stk_data,
   output logic [7:0]       psw_rd,
   output logic [N_SRC-1:0] flag_rd,
   output logic [N_SRC-1:0] mask_rd
);
   if (N_SRC < 2 || N_SRC > 32) begin : g_bad_nsrc
      $error("mvic_top: N_SRC must lie in 2..32");
   end
   if (VEC_W < $clog2(N_SRC)) begin : g_bad_vecw
      $error("mvic_top: VEC_W too narrow for N_SRC");
   end

   logic [N_SRC-1:0] elig, grant, clr_onehot;
   logic             any_elig, take;
   logic [7:0]       psw_q;
   psw_cmd_t         cmd;

   mvic_flags #(.N_SRC(N_SRC)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_pulse  (req_pulse),
      .flag_we    (flag_wr_en),
      .flag_d     (flag_wr_data),
      .mask_we    (mask_wr_en),
      .mask_d     (mask_wr_data),
      .clr_onehot (clr_onehot),
      .flag_q     (flag_rd),
      .mask_q     (mask_rd),
      .elig       (elig)
   );

   mvic_prio #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_prio (
      .elig  (elig),
      .any   (any_elig),
      .grant (grant),
      .vec   (irq_vec)
   );

   assign irq_out    = any_elig & psw_q[IE_POS];
   assign take       = ack_in & irq_out;
   assign clr_onehot = grant & {N_SRC{take}};

   always_comb begin
      cmd.byte_we = psw_wr_en;
      cmd.byte_d  = psw_wr_data;
      cmd.bit_we  = psw_bit_we;
      cmd.bit_sel = psw_bit_sel;
      cmd.bit_d   = psw_bit_val;
      cmd.en_set  = ie_set;
      cmd.en_clr  = ie_clr;
      cmd.take    = take;
   end

   mvic_psw u_psw (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .psw_q (psw_q)
   );

   assign stk_push = take;
   assign stk_data = psw_q;
   assign psw_rd   = psw_q;
endmodule

// File: rtl/mvic_chk.sv
`timescale 1ns/1ps
module mvic_chk #(
   parameter int N_SRC = 8,
   parameter int VEC_W = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] req_pulse,
   input logic             flag_wr_en,
   input logic             irq_out,
   input logic [VEC_W-1:0] irq_vec,
   input logic             stk_push,
   input logic [7:0]       psw_rd,
   input logic [N_SRC-1:0] flag_rd,
   input logic [N_SRC-1:0] mask_rd
);
   AST_VEC_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (flag_rd[irq_vec] && !mask_rd[irq_vec])); // R1
   AST_NO_IRQ_IE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !psw_rd[7] |-> !irq_out); // R2
   AST_PUSH_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push |=> !psw_rd[7]); // R3
   AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_rd[1] && !psw_rd[5] && !psw_rd[3] && !psw_rd[2])); // R5
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (((flag_rd & ~mask_rd) &
                    ((N_SRC'(1) << irq_vec) - N_SRC'(1))) == '0)); // R6
   AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push && !req_pulse[irq_vec] && !flag_wr_en)
      |=> !flag_rd[$past(irq_vec)]); // R7
   AST_NO_PUSH_WITHOUT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> !stk_push); // R9
endmodule

bind mvic_top mvic_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_pulse  (req_pulse),
   .flag_wr_en (flag_wr_en),
   .irq_out    (irq_out),
   .irq_vec    (irq_vec),
   .stk_push   (stk_push),
   .psw_rd     (psw_rd),
   .flag_rd    (flag_rd),
   .mask_rd    (mask_rd)
);

// File: tb/mvic_top_bench.sv
`timescale 1ns/1ps
module mvic_top_bench;
   localparam int N = 8;
   localparam int VW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] req_pulse = '0;
   logic flag_wr_en = 1'b0;
   logic [N-1:0] flag_wr_data = '0;
   logic mask_wr_en = 1'b0;
   logic [N-1:0] mask_wr_data = '0;
   logic psw_wr_en = 1'b0;
   logic [7:0] psw_wr_data = '0;
   logic psw_bit_we = 1'b0;
   logic [2:0] psw_bit_sel = '0;
   logic psw_bit_val = 1'b0;
   logic ie_set = 1'b0;
   logic ie_clr = 1'b0;
   logic ack_in = 1'b0;
   logic irq_out, stk_push;
   logic [VW-1:0] irq_vec;
   logic [7:0] stk_data, psw_rd;
   logic [N-1:0] flag_rd, mask_rd;

   int n_chk = 0;
   int n_fail = 0;
   logic [N-1:0] m_flag = '0;
   logic [N-1:0] m_mask = '1;
   logic [7:0]   m_psw  = 8'h02;

   always #5 clk = ~clk;

   mvic_top #(.N_SRC(N)) u_mvic_top (
      .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse),
      .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
      .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
      .psw_bit_we(psw_bit_we), .psw_bit_sel(psw_bit_sel), .psw_bit_val(psw_bit_val),
      .ie_set(ie_set), .ie_clr(ie_clr), .ack_in(ack_in),
      .irq_out(irq_out), .irq_vec(irq_vec), .stk_push(stk_push), .stk_data(stk_data),
      .psw_rd(psw_rd), .flag_rd(flag_rd), .mask_rd(mask_rd));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] legal(input logic [7:0] v);
      return (v & 8'hD3) | 8'h02;
   endfunction

   function automatic int low_idx(input logic [N-1:0] e);
      for (int i = 0; i < N; i++) if (e[i]) return i;
      return 0;
   endfunction

   function automatic bit m_irq();
      return (|(m_flag & ~m_mask)) && m_psw[7];
   endfunction

   // Entered just after a falling edge with inputs already set.
   task automatic cyc();
      logic [N-1:0] e, nf;
      logic [7:0] np;
      bit ie, push;
      int v;
      #1;
      e = m_flag & ~m_mask;
      ie = m_irq();
      v = low_idx(e);
      push = ack_in && ie;
      chk(psw_rd == m_psw, "R10 psw", psw_rd, m_psw);
      chk(flag_rd == m_flag, "R8 flags", flag_rd, m_flag);
      chk(mask_rd == m_mask, "R11 mask", mask_rd, m_mask);
      chk(irq_out == ie, "R2 irq", irq_out, ie);
      if (ie) chk(irq_vec == VW'(v), "R6 vec", irq_vec, v);
      chk(stk_push == push, "R3 push", stk_push, push);
      if (push) chk(stk_data == m_psw, "R3 data", stk_data, m_psw);
      nf = flag_wr_en ? flag_wr_data : m_flag;
      if (push) nf[v] = 1'b0;
      nf = nf | req_pulse;
      np = m_psw;
      if (psw_wr_en) np = psw_wr_data;
      if (psw_bit_we) np[psw_bit_sel] = psw_bit_val;
      if (ie_set) np[7] = 1'b1;
      if (ie_clr) np[7] = 1'b0;
      if (push) np[7] = 1'b0;
      @(posedge clk);
      m_flag = nf;
      m_psw = legal(np);
      if (mask_wr_en) m_mask = mask_wr_data;
      @(negedge clk);
      req_pulse = '0; flag_wr_en = 0; mask_wr_en = 0; psw_wr_en = 0;
      psw_bit_we = 0; ie_set = 0; ie_clr = 0; ack_in = 0;
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int wait_c;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      chk(psw_rd == 8'h02, "R4 psw reset", psw_rd, 8'h02);
      chk(mask_rd == '1, "R4 mask reset", mask_rd, 8'hFF);
      chk(flag_rd == '0, "R4 flag reset", flag_rd, 0);
      chk(irq_out == 1'b0, "R4 irq reset", irq_out, 0);
      rst_n = 1'b1;
      @(negedge clk);

      mask_wr_en = 1; mask_wr_data = '0; cyc();
      chk(mask_rd == '0, "R11 mask write", mask_rd, 0);
      req_pulse = 8'h04; cyc();
      chk(flag_rd[2] == 1'b1, "R8 pulse sets", flag_rd, 8'h04);
      chk(irq_out == 1'b0, "R2 IE low", irq_out, 0);
      ie_set = 1; cyc();
      chk(irq_out && irq_vec == 3'd2, "R1 eligible", irq_vec, 2);
      req_pulse = 8'h21; cyc();
      chk(irq_vec == 3'd0, "R6 lowest wins", irq_vec, 0);
      ack_in = 1; req_pulse = 8'h01; #1;
      chk(stk_push && stk_data == 8'h82, "R3 push byte", stk_data, 8'h82);
      cyc();
      chk(flag_rd == 8'h25, "R7 re-set by pulse", flag_rd, 8'h25);
      chk(psw_rd[7] == 1'b0, "R3 IE cleared", psw_rd, 8'h02);
      ack_in = 1; cyc();
      chk(flag_rd == 8'h25 && psw_rd == 8'h02, "R9 stray ack", flag_rd, 8'h25);
      psw_wr_en = 1; psw_wr_data = 8'hFF; cyc();
      chk(psw_rd == 8'hD3, "R5 fixed bits", psw_rd, 8'hD3);
      psw_bit_we = 1; psw_bit_sel = 3'd1; psw_bit_val = 0; cyc();
      chk(psw_rd == 8'hD3, "R5 bit1 stays", psw_rd, 8'hD3);
      psw_bit_we = 1; psw_bit_sel = 3'd6; psw_bit_val = 0; cyc();
      chk(psw_rd == 8'h93, "R10 bit write", psw_rd, 8'h93);
      ie_set = 1; ie_clr = 1; cyc();
      chk(psw_rd == 8'h13, "R10 clr over set", psw_rd, 8'h13);
      psw_wr_en = 1; psw_wr_data = 8'h00; ie_set = 1; cyc();
      chk(psw_rd == 8'h82, "R10 set over byte", psw_rd, 8'h82);
      ack_in = 1; cyc();
      chk(flag_rd == 8'h24, "R7 winner cleared", flag_rd, 8'h24);
      flag_wr_en = 1; flag_wr_data = 8'h40; req_pulse = 8'h01; cyc();
      chk(flag_rd == 8'h41, "R8 pulse over write", flag_rd, 8'h41);
      flag_wr_en = 1; flag_wr_data = '0; ie_set = 1; cyc();
      req_pulse = 8'h80; #1;
      chk(irq_out == 1'b0, "R12 not yet", irq_out, 0);
      cyc();
      chk(irq_out && irq_vec == 3'd7, "R12 one edge", irq_vec, 7);
      mask_wr_en = 1; mask_wr_data = 8'h80; cyc();
      chk(irq_out == 1'b0, "R1 masked drops", irq_out, 0);

      wait_c = 0;
      for (int k = 0; k < 4000; k++) begin
         req_pulse = ($urandom % 6 == 0) ? N'($urandom & $urandom) : '0;
         if ($urandom % 40 == 0) begin flag_wr_en = 1; flag_wr_data = N'($urandom); end
         if ($urandom % 50 == 0) begin mask_wr_en = 1; mask_wr_data = N'($urandom & $urandom); end
         if ($urandom % 60 == 0) begin psw_wr_en = 1; psw_wr_data = 8'($urandom); end
         if ($urandom % 30 == 0) begin
            psw_bit_we = 1; psw_bit_sel = 3'($urandom); psw_bit_val = 1'($urandom);
         end
         if (!m_psw[7] && $urandom % 8 == 0) ie_set = 1;
         if ($urandom % 90 == 0) ie_clr = 1;
         if (wait_c == 0 && m_irq()) wait_c = 9 + int'($urandom % 11);
         if (wait_c > 0) begin
            wait_c--;
            if (wait_c == 0) ack_in = 1;
         end
         if ($urandom % 200 == 0) ack_in = 1;
         cyc();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule